// File: doc/BRIEF.md
# I2C Slave Address-Match Receiver

This block is the receive half of an I2C slave. It samples the open-drain SCL and SDA lines in the system clock domain and detects Start, Repeated Start and Stop. It shifts each byte in MSB first and checks the address byte against a compare register that the host writes. The block then either pulls SDA low for the acknowledge slot or leaves it released. Bytes that are accepted go into a holding buffer. The host sees four status bits: buffer full, overflow, update-address and read/write. An interrupt flag is raised at the end of every byte that concerns this slave.

Two addressing schemes are supported. In 7-bit mode, bits 7:1 of the first byte are compared with bits 7:1 of the compare register. In 10-bit mode the first byte carries the tag `11110` and the two top address bits. After each matched address byte, the block holds SCL low until the host rewrites the compare register with the other half of the address. When the full 10-bit address has matched, a Repeated Start followed by the high byte with the read bit set addresses the slave for a read.

Top module: `i2c_addr_rx`

## Requirements
- R1: A Start or Repeated Start is SDA falling while SCL is high, and it begins a new address byte. A Stop is SDA rising while SCL is high, and it returns the block to idle. Bytes clocked after a Stop and before the next Start get no acknowledge and raise no interrupt.
- R2: Bits are sampled on rising SCL, MSB first. In 7-bit mode the slave is addressed when received bits 7:1 equal compare-register bits 7:1. An unaddressed byte gets no acknowledge and changes no status bit.
- R3: An accepted byte (address or data) is copied into the holding buffer and sets buffer-full. After reset, all status bits, the interrupt flag and both pull enables are 0.
- R4: The interrupt flag is set at the falling edge of the ninth SCL pulse of every byte that concerns this slave, including blocked ones. Only `irq_clr` clears it; reading the buffer does not.
- R5: If buffer-full or overflow is set when a byte completes, the buffer keeps its old value and SDA is not pulled. Completion with buffer-full set also sets overflow, which only `ovf_clr` clears.
- R6: A `buf_rd` pulse clears buffer-full.
- R7: On a matched address byte, read/write takes bit 0 of that byte (1 = read).
- R8: In 10-bit mode, a first byte `11110 A9 A8 0` that equals compare-register bits 7:1 is acknowledged and sets update-address. SCL is then held low from the ninth falling edge until the host writes the compare register. That write clears update-address and releases SCL.
- R9: In 10-bit mode, the second address byte must equal all 8 compare-register bits. On a match the block behaves as in R8. On a mismatch there is no acknowledge, no SCL hold and no interrupt.
- R10: In 10-bit mode, once the full address has matched, a high byte with bit 0 = 1 after a Repeated Start is acknowledged, loaded, sets read/write and the interrupt, and does not hold SCL. Without a prior full match the same byte is not acknowledged.
- R11: SDA is pulled only from the eighth SCL falling edge to the ninth of an accepted byte. The SCL and SDA outputs are pull-low enables only and are never both active at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low (clock hold) |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| addr_wr_en | input | 1 | Write strobe for the compare register |
| addr_wr_data | input | 8 | Compare register write value |
| buf_rd | input | 1 | Host read of the holding buffer |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| rx_buf | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Holding buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| upd_addr | output | 1 | Host must rewrite the compare register |
| rd_wr | output | 1 | Direction bit of the last matched address |
| irq | output | 1 | Per-byte interrupt flag |

## Verification
The hardest state to reach from the ports is the 10-bit read. It needs a full two-byte match, two clock holds, each released by a compare-register rewrite, and then a Repeated Start in the same transfer. The bench plays a bus master that honours clock stretching and acts as the host between bytes in the required order. A second sweep over every possible first byte in 10-bit mode shows that the read byte is refused when the earlier match is missing. Overflow is reached by leaving the buffer unread across a second data byte. It is then cleared in two separate steps to cover the remaining status combinations.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA,
    ST_SKIP
  } rx_state_t;

  // 7-bit match: address bits live in 7:1 of both words
  function automatic logic addr7_hit(input logic [BYTE_W-1:0] rx, input logic [BYTE_W-1:0] cmp);
    return rx[BYTE_W-1:1] == cmp[BYTE_W-1:1];
  endfunction

  // first byte of a 10-bit address: tag plus A9 A8 against the register
  function automatic logic hi10_hit(input logic [BYTE_W-1:0] rx, input logic [BYTE_W-1:0] cmp);
    return (rx[BYTE_W-1:BYTE_W-5] == TEN_BIT_TAG) && (rx[BYTE_W-1:1] == cmp[BYTE_W-1:1]);
  endfunction

  // second byte of a 10-bit address: full equality
  function automatic logic lo10_hit(input logic [BYTE_W-1:0] rx, input logic [BYTE_W-1:0] cmp);
    return rx == cmp;
  endfunction

  function automatic logic may_accept(input logic bf, input logic ov);
    return !bf && !ov;
  endfunction

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  generate
    if (STAGES < 1) begin : g_bad
      initial $error("STAGES must be at least 1");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[LAST-1:0], d};
  end

  assign q      = chain[LAST-1];
  assign q_prev = chain[LAST];
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
  input  logic scl,
  input  logic scl_p,
  input  logic sda,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_high_both;

  assign scl_high_both = scl & scl_p;
  assign scl_rise  = scl & ~scl_p;
  assign scl_fall  = ~scl & scl_p;
  assign start_det = scl_high_both & sda_p & ~sda;
  assign stop_det  = scl_high_both & ~sda_p & sda;
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              ack_end
);
  localparam int CNT_W = $clog2(BYTE_W + 3);
  localparam logic [CNT_W-1:0] C_FULL    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] C_ACK_LOW = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] C_ACK_HI  = CNT_W'(BYTE_W + 2);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr;

  assign byte_done = enable && scl_fall && (cnt == C_FULL);
  assign ack_end   = enable && scl_fall && (cnt == C_ACK_HI);
  assign rx_byte   = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (enable) begin
      if (scl_rise && cnt < C_FULL) begin
        sr  <= {sr[BYTE_W-2:0], sda};
        cnt <= cnt + 1'b1;
      end else if (scl_rise && cnt == C_ACK_LOW) begin
        cnt <= C_ACK_HI;
      end else if (byte_done) begin
        cnt <= C_ACK_LOW;
      end else if (ack_end) begin
        cnt <= '0;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              ten_bit_mode,
  input  logic              addr_wr_en,
  input  logic [BYTE_W-1:0] addr_wr_data,
  input  logic              buf_rd,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              overflow,
  output logic              upd_addr,
  output logic              rd_wr,
  output logic              irq
);
  localparam int LINES = 2;

  // synchronised lines: index 0 = SCL, 1 = SDA
  logic [LINES-1:0] line_raw, line_s, line_p;
  assign line_raw = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_sync
      i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g]), .q_prev(line_p[g])
      );
    end
  endgenerate

  // named bus events
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_rx_cond u_cond (
    .scl(line_s[0]), .scl_p(line_p[0]), .sda(line_s[1]), .sda_p(line_p[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  rx_state_t         state, nxt_q, nxt_d;
  logic              counting, byte_done, ack_end;
  logic [BYTE_W-1:0] rx_byte;

  assign counting = (state != ST_IDLE) && (state != ST_SKIP);

  i2c_rx_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .restart(start_det | stop_det), .enable(counting),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(line_s[1]),
    .rx_byte(rx_byte), .byte_done(byte_done), .ack_end(ack_end)
  );

  logic [BYTE_W-1:0] cmp_reg, buf_reg;
  logic bf_q, ovf_q, ua_q, rw_q, irq_q, ack_q, hold_q;
  logic pend_irq, pend_ua, ten_ok;

  // decision made at the falling edge of the eighth pulse
  logic is_read, hit, accept, byte_load, ovf_set, ua_due;

  assign is_read = rx_byte[0];

  always_comb begin
    hit   = 1'b0;
    nxt_d = ST_SKIP;
    unique case (state)
      ST_ADDR_HI: begin
        if (!ten_bit_mode) begin
          hit   = addr7_hit(rx_byte, cmp_reg);
          nxt_d = is_read ? ST_SKIP : ST_DATA;
        end else begin
          hit   = hi10_hit(rx_byte, cmp_reg) && (!is_read || ten_ok);
          nxt_d = is_read ? ST_SKIP : ST_ADDR_LO;
        end
      end
      ST_ADDR_LO: begin
        hit   = lo10_hit(rx_byte, cmp_reg);
        nxt_d = ST_DATA;
      end
      ST_DATA: begin
        hit   = 1'b1;
        nxt_d = ST_DATA;
      end
      default: begin
        hit   = 1'b0;
        nxt_d = ST_SKIP;
      end
    endcase
    accept = hit && may_accept(bf_q, ovf_q);
    if (!accept && state != ST_DATA) nxt_d = ST_SKIP;
  end

  assign byte_load = byte_done && accept;
  assign ovf_set   = byte_done && hit && bf_q;
  assign ua_due    = accept && ten_bit_mode &&
                     ((state == ST_ADDR_HI && !is_read) || state == ST_ADDR_LO);

  // bus sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      ack_q    <= 1'b0;
      pend_irq <= 1'b0;
      pend_ua  <= 1'b0;
      ten_ok   <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      ack_q    <= 1'b0;
      pend_irq <= 1'b0;
      pend_ua  <= 1'b0;
      ten_ok   <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR_HI;
      ack_q    <= 1'b0;
      pend_irq <= 1'b0;
      pend_ua  <= 1'b0;
    end else if (byte_done) begin
      ack_q    <= accept;
      pend_irq <= hit;
      pend_ua  <= ua_due;
      nxt_q    <= nxt_d;
      if (accept && ten_bit_mode && state == ST_ADDR_HI && !is_read) ten_ok <= 1'b0;
      if (accept && state == ST_ADDR_LO) ten_ok <= 1'b1;
    end else if (ack_end) begin
      ack_q    <= 1'b0;
      pend_irq <= 1'b0;
      pend_ua  <= 1'b0;
      state    <= nxt_q;
    end
  end

  // host-visible status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_reg <= '0;
      buf_reg <= '0;
      bf_q    <= 1'b0;
      ovf_q   <= 1'b0;
      ua_q    <= 1'b0;
      rw_q    <= 1'b0;
      irq_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      if (addr_wr_en) cmp_reg <= addr_wr_data;

      if (byte_load) begin
        buf_reg <= rx_byte;
        bf_q    <= 1'b1;
      end else if (buf_rd) begin
        bf_q    <= 1'b0;
      end

      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;

      if (byte_done && hit && state == ST_ADDR_HI) rw_q <= is_read;

      if (ack_end && pend_irq) irq_q <= 1'b1;
      else if (irq_clr)        irq_q <= 1'b0;

      if (ack_end && pend_ua) begin
        ua_q   <= 1'b1;
        hold_q <= 1'b1;
      end else if (addr_wr_en) begin
        ua_q   <= 1'b0;
        hold_q <= 1'b0;
      end
    end
  end

  assign scl_pull = hold_q;
  assign sda_pull = ack_q;
  assign rx_buf   = buf_reg;
  assign buf_full = bf_q;
  assign overflow = ovf_q;
  assign upd_addr = ua_q;
  assign rd_wr    = rw_q;
  assign irq      = irq_q;
endmodule

// File: rtl/i2c_addr_rx_chk.sv
module i2c_addr_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_pull,
  input logic sda_pull,
  input logic upd_addr,
  input logic buf_full,
  input logic overflow,
  input logic irq,
  input logic irq_clr,
  input logic ovf_clr,
  input logic addr_wr_en,
  input logic byte_done,
  input logic byte_load
);
  AST_PULLS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_pull && sda_pull)); // R11

  AST_HOLD_NEEDS_UA: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> upd_addr); // R8

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && addr_wr_en) |=> !scl_pull); // R8

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load |=> buf_full); // R3

  AST_BLOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (buf_full || overflow)) |-> !byte_load); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow); // R5
endmodule

bind i2c_addr_rx i2c_addr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .upd_addr(upd_addr), .buf_full(buf_full), .overflow(overflow), .irq(irq),
  .irq_clr(irq_clr), .ovf_clr(ovf_clr), .addr_wr_en(addr_wr_en),
  .byte_done(byte_done), .byte_load(byte_load)
);

// File: tb/i2c_addr_rx_test.sv
module i2c_addr_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ten_bit_mode = 1'b0, addr_wr_en = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] addr_wr_data = 8'h00;
  logic scl_pull, sda_pull, buf_full, overflow, upd_addr, rd_wr, irq;
  logic [7:0] rx_buf;
  logic scl_line, sda_line;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .ten_bit_mode(ten_bit_mode),
    .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data), .buf_rd(buf_rd),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rx_buf(rx_buf), .buf_full(buf_full),
    .overflow(overflow), .upd_addr(upd_addr), .rd_wr(rd_wr), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scl_up();
    int guard = 0;
    scl_m = 1'b1;
    tick(1);
    while (!scl_line && guard < 5000) begin
      tick(1);
      guard++;
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_up();     tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_up();     tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_up();  tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_up(); tick(Q/2);
    acked = ~sda_line;
    tick(Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic host_wr(input logic [7:0] v);
    addr_wr_data = v; addr_wr_en = 1'b1; tick(1); addr_wr_en = 1'b0; tick(2);
  endtask

  task automatic host_clear();
    buf_rd = 1'b1; irq_clr = 1'b1; tick(1); buf_rd = 1'b0; irq_clr = 1'b0; tick(1);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic ak;
    tick(4); rst_n = 1'b1; tick(4);
    // R3 reset state
    chk("R3 reset flags", {irq, buf_full, overflow, upd_addr, rd_wr}, 0);
    chk("R11 reset pulls", {scl_pull, sda_pull}, 0);

    // 7-bit sweep over all addresses, compare value 0x52
    host_wr(8'hA4);
    for (int a = 0; a < 128; a++) begin
      logic rw;
      logic [7:0] b;
      rw = a[0] ^ a[3];
      b = {a[6:0], rw};
      bus_start(); send_byte(b, ak); bus_stop(); tick(2);
      chk("R2 ack vs match", ak, (a == 8'h52));
      chk("R4 irq on address", irq, (a == 8'h52));
      chk("R3 buffer full", buf_full, (a == 8'h52));
      if (a == 8'h52) begin
        chk("R3 buffer value", rx_buf, b);
        chk("R7 direction bit", rd_wr, rw);
      end
      host_clear();
    end

    // data path and blocking combinations
    bus_start(); send_byte(8'hA4, ak); chk("R2 write addr ack", ak, 1);
    chk("R7 write dir", rd_wr, 0);
    host_clear();
    send_byte(8'h3C, ak);
    chk("R3 data ack", ak, 1); chk("R3 data buf", rx_buf, 8'h3C);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
    send_byte(8'hC3, ak);
    chk("R5 full no ack", ak, 0); chk("R5 ovf set", overflow, 1);
    chk("R5 buf kept", rx_buf, 8'h3C); chk("R4 irq when blocked", irq, 1);
    buf_rd = 1'b1; tick(1); buf_rd = 1'b0; tick(1);
    chk("R6 read clears full", buf_full, 0);
    chk("R4 read keeps irq", irq, 1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
    chk("R4 irq_clr", irq, 0);
    send_byte(8'h99, ak);
    chk("R5 ovf blocks ack", ak, 0); chk("R5 ovf blocks load", {buf_full, rx_buf}, {1'b0, 8'h3C});
    chk("R4 irq ovf only", irq, 1);
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(1);
    chk("R5 ovf_clr", overflow, 0);
    host_clear();
    send_byte(8'h77, ak);
    chk("R5 clean accept", ak, 1); chk("R3 buf 77", rx_buf, 8'h77);
    host_clear();
    // R1 repeated start with read
    bus_start(); send_byte(8'hA5, ak);
    chk("R1 repeated start ack", ak, 1); chk("R7 read dir", rd_wr, 1);
    bus_stop(); host_clear();
    // R1 no start after stop
    send_byte(8'hA4, ak); tick(2);
    chk("R1 idle no ack", ak, 0); chk("R1 idle no irq", irq, 0);
    bus_start(); bus_stop(); host_clear();

    // 10-bit addressing, address 0x2B5: high F4, low B5
    ten_bit_mode = 1'b1; host_wr(8'hF4);
    bus_start(); send_byte(8'hF4, ak); tick(2);
    chk("R8 hi ack", ak, 1); chk("R8 hi ua", upd_addr, 1);
    chk("R8 hi hold", scl_pull, 1); chk("R8 hi buf", rx_buf, 8'hF4);
    chk("R11 no ack pull while hold", sda_pull, 0);
    host_clear();
    chk("R8 read keeps hold", scl_pull, 1);
    host_wr(8'hB5);
    chk("R8 write releases", {scl_pull, upd_addr}, 0);
    send_byte(8'hB5, ak); tick(2);
    chk("R9 lo ack", ak, 1); chk("R9 lo hold", {scl_pull, upd_addr}, 2'b11);
    host_clear(); host_wr(8'hF4);
    chk("R9 release", {scl_pull, upd_addr}, 0);
    send_byte(8'h5E, ak); tick(2);
    chk("R3 10-bit data", {ak, rx_buf}, {1'b1, 8'h5E});
    chk("R8 no hold on data", scl_pull, 0);
    host_clear();
    bus_start(); send_byte(8'hF5, ak); tick(2);
    chk("R10 read ack", ak, 1); chk("R10 read dir", rd_wr, 1);
    chk("R10 read flags", {buf_full, irq, scl_pull}, 3'b110);
    bus_stop(); host_clear();

    // R9 wrong low byte
    bus_start(); send_byte(8'hF4, ak); host_clear(); host_wr(8'hB5);
    send_byte(8'hB4, ak); tick(2);
    chk("R9 lo mismatch", {ak, scl_pull, upd_addr, irq}, 0);
    bus_stop(); host_clear(); host_wr(8'hF4);

    // sweep of every first byte in 10-bit mode, no earlier full match
    for (int v = 0; v < 256; v++) begin
      logic exp_hit;
      exp_hit = (v == 8'hF4);
      bus_start(); send_byte(v[7:0], ak); tick(2);
      chk("R10 hi sweep ack", ak, exp_hit);
      chk("R8 hi sweep hold", scl_pull, exp_hit);
      if (exp_hit) begin
        host_clear(); host_wr(8'hB5);
      end
      bus_stop(); host_clear();
      if (exp_hit) host_wr(8'hF4);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule